// File: doc/BRIEF.md
# Prioritised Autovector Interrupt Arbiter

This block sits between a set of interrupt request sources and a processor core. Requests arrive as one strobe per priority level, from 1 to 7, and each one is latched into a sticky pending bit. Every cycle the arbiter compares the highest pending level with the processor's current 3-bit mask. It then presents a registered decision: whether an interrupt should be taken, at which level, and the byte offset of that level's autovector slot in the exception table. Level 7 cannot be masked.

The core accepts a presented interrupt by pulsing the acknowledge input. The arbiter then clears the serviced pending bit. One cycle later it reports the new mask, which equals the serviced level, and the new trace-enable pair, which is cleared. It also gives a one-cycle resume pulse that releases a halted core. When no interrupt is being accepted, the new-mask and new-trace outputs follow the core's current values with a delay of one cycle. The vector offset is computed from the level with arithmetic and no lookup table.

Top module: `irq_autovec_arb`

## Requirements
- R1: While reset is held and right after it, take, level, vecOffset, newMask, newTrace and resume are all zero, and no level is pending.
- R2: When no pending bit is set, take stays 0.
- R3: A pending level 7 is presented with take=1 and level=7 for any curMask value, including 7.
- R4: When level 7 is not pending, the highest pending level from 6 down to 1 is chosen. It is taken only if it is strictly greater than curMask, so a level equal to the mask is not taken.
- R5: When take=1, vecOffset = (level + 24) * 4, for example 100 for level 1 and 124 for level 7. When take=0, level and vecOffset are both 0.
- R6: An acknowledge while take=1 is an acceptance. In the next cycle resume=1, newMask equals the accepted level and newTrace=2'b00. In any other cycle, resume=0, and newMask and newTrace equal the curMask and traceIn values of the previous cycle.
- R7: An acceptance clears the pending bit of the serviced level and leaves the other pending bits set. This shows at the ports as the next-lower pending level being presented two cycles later.
- R8: If a new request for a level arrives in the same cycle that level is accepted, the level stays pending.
- R9: An acknowledge while take=0 is ignored: it changes no pending bit and produces no resume pulse.
- R10: A one-cycle request pulse (bit i of reqSet stands for level i+1) stays pending until that level is accepted.
- R11: take, level and vecOffset are registered. They reflect the pending bits and curMask of the previous cycle, so the presented level still holds in the cycle right after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqSet | input | 7 | Request strobes; bit i requests level i+1 |
| curMask | input | 3 | Current processor interrupt mask |
| traceIn | input | 2 | Current trace-enable pair |
| ack | input | 1 | Acknowledge of the presented interrupt |
| take | output | 1 | An interrupt should be taken |
| level | output | 3 | Presented level, 0 when none |
| vecOffset | output | 8 | Autovector byte offset |
| newMask | output | 3 | Mask after the last cycle |
| newTrace | output | 2 | Trace-enable pair after the last cycle |
| resume | output | 1 | One-cycle pulse that releases a halted core |

## Verification
The hardest situation to reach is an acceptance that coincides with a fresh request for the very level being serviced. The acknowledge has to land exactly while the registered take is high, and the matching reqSet bit has to be driven in that same cycle. Directed sequences first build up a known pending state. They then issue the acknowledge and the same-level request together, and watch whether that level is presented again two cycles later. A long stretch of random requests, masks and acknowledges follows. A behavioural model checks every output on every clock.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int IRQ_LEVELS = 7;
  localparam int LVL_W      = $clog2(IRQ_LEVELS + 1);
  localparam int TRACE_W    = 2;

  typedef logic [LVL_W-1:0] lvl_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;     // acknowledge hit a presented interrupt
    logic takeNext;   // decision for next cycle
    lvl_t levelNext;  // chosen level, 0 when none
  } arbStrobes_t;
endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
(
  input  logic [IRQ_LEVELS-1:0] pendQ,
  input  lvl_t                  curMask,
  input  logic                  takeQ,
  input  logic                  ack,
  output arbStrobes_t           strobes
);
  lvl_t hiLvl;
  logic nmiPend;

  always_comb begin
    hiLvl = '0;
    for (int i = 1; i <= IRQ_LEVELS; i++) begin
      if (pendQ[i-1]) hiLvl = lvl_t'(i);
    end
  end

  assign nmiPend = pendQ[IRQ_LEVELS-1];

  always_comb begin
    strobes.takeNext  = nmiPend || (hiLvl > curMask);
    strobes.levelNext = strobes.takeNext ? hiLvl : '0;
    strobes.accept    = ack && takeQ;
  end
endmodule

// File: rtl/irq_arb_dp.sv
module irq_arb_dp
  import irq_arb_pkg::*;
#(
  parameter int VEC_BASE  = 24,
  parameter int VEC_SCALE = 4,
  parameter int OFS_W     = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [IRQ_LEVELS-1:0] reqSet,
  input  lvl_t                  curMask,
  input  logic [TRACE_W-1:0]    traceIn,
  input  arbStrobes_t           strobes,
  output logic [IRQ_LEVELS-1:0] pendQ,
  output logic                  takeQ,
  output lvl_t                  levelQ,
  output logic [OFS_W-1:0]      ofsQ,
  output lvl_t                  maskQ,
  output logic [TRACE_W-1:0]    traceQ,
  output logic                  resumeQ
);
  logic [IRQ_LEVELS-1:0] clrVec;
  logic [IRQ_LEVELS-1:0] pendNext;
  logic [OFS_W-1:0]      ofsNext;

  for (genvar g = 0; g < IRQ_LEVELS; g++) begin : g_clr
    assign clrVec[g] = strobes.accept && (levelQ == lvl_t'(g + 1));
  end

  // a new request beats the clear of the same level
  assign pendNext = (pendQ & ~clrVec) | reqSet;
  assign ofsNext  = strobes.takeNext
                  ? OFS_W'((int'(strobes.levelNext) + VEC_BASE) * VEC_SCALE)
                  : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= '0;
      takeQ   <= 1'b0;
      levelQ  <= '0;
      ofsQ    <= '0;
      maskQ   <= '0;
      traceQ  <= '0;
      resumeQ <= 1'b0;
    end else begin
      pendQ   <= pendNext;
      takeQ   <= strobes.takeNext;
      levelQ  <= strobes.levelNext;
      ofsQ    <= ofsNext;
      maskQ   <= strobes.accept ? levelQ : curMask;
      traceQ  <= strobes.accept ? '0 : traceIn;
      resumeQ <= strobes.accept;
    end
  end
endmodule

// File: rtl/irq_autovec_arb.sv
module irq_autovec_arb
  import irq_arb_pkg::*;
#(
  parameter int VEC_BASE  = 24,
  parameter int VEC_SCALE = 4,
  parameter int OFS_W     = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [IRQ_LEVELS-1:0] reqSet,
  input  logic [LVL_W-1:0]      curMask,
  input  logic [TRACE_W-1:0]    traceIn,
  input  logic                  ack,
  output logic                  take,
  output logic [LVL_W-1:0]      level,
  output logic [OFS_W-1:0]      vecOffset,
  output logic [LVL_W-1:0]      newMask,
  output logic [TRACE_W-1:0]    newTrace,
  output logic                  resume
);
  arbStrobes_t           strobes;
  logic [IRQ_LEVELS-1:0] pendQ;

  irq_arb_ctrl u_ctrl (
    .pendQ   (pendQ),
    .curMask (curMask),
    .takeQ   (take),
    .ack     (ack),
    .strobes (strobes)
  );

  irq_arb_dp #(
    .VEC_BASE  (VEC_BASE),
    .VEC_SCALE (VEC_SCALE),
    .OFS_W     (OFS_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .reqSet  (reqSet),
    .curMask (curMask),
    .traceIn (traceIn),
    .strobes (strobes),
    .pendQ   (pendQ),
    .takeQ   (take),
    .levelQ  (level),
    .ofsQ    (vecOffset),
    .maskQ   (newMask),
    .traceQ  (newTrace),
    .resumeQ (resume)
  );
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker
  import irq_arb_pkg::*;
#(
  parameter int VEC_BASE  = 24,
  parameter int VEC_SCALE = 4,
  parameter int OFS_W     = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [IRQ_LEVELS-1:0] reqSet,
  input logic [LVL_W-1:0]      curMask,
  input logic                  ack,
  input logic                  take,
  input logic [LVL_W-1:0]      level,
  input logic [OFS_W-1:0]      vecOffset,
  input logic [LVL_W-1:0]      newMask,
  input logic [TRACE_W-1:0]    newTrace,
  input logic                  resume,
  input logic [IRQ_LEVELS-1:0] pendQ
);
  a_r3_nmi_taken: assert property (@(posedge clk) disable iff (!rstN)
    pendQ[IRQ_LEVELS-1] |=> (take && level == LVL_W'(IRQ_LEVELS)));

  a_r4_above_mask: assert property (@(posedge clk) disable iff (!rstN)
    take |-> (level == LVL_W'(IRQ_LEVELS) || level > $past(curMask)));

  a_r5_offset: assert property (@(posedge clk) disable iff (!rstN)
    take |-> vecOffset == OFS_W'((int'(level) + VEC_BASE) * VEC_SCALE));

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !take |-> (level == '0 && vecOffset == '0));

  a_r6_accept: assert property (@(posedge clk) disable iff (!rstN)
    (ack && take) |=> (resume && newMask == $past(level) && newTrace == '0));

  a_r9_no_resume: assert property (@(posedge clk) disable iff (!rstN)
    !(ack && take) |=> !resume);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ack && take && (reqSet & (IRQ_LEVELS'(1) << (level - 1'b1))) == '0)
      |=> !pendQ[$past(level) - 1'b1]);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & $past(reqSet)) == $past(reqSet)));
endmodule

bind irq_autovec_arb irq_arb_checker #(
  .VEC_BASE  (VEC_BASE),
  .VEC_SCALE (VEC_SCALE),
  .OFS_W     (OFS_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqSet    (reqSet),
  .curMask   (curMask),
  .ack       (ack),
  .take      (take),
  .level     (level),
  .vecOffset (vecOffset),
  .newMask   (newMask),
  .newTrace  (newTrace),
  .resume    (resume),
  .pendQ     (pendQ)
);

// File: tb/irq_autovec_arb_test.sv
module irq_autovec_arb_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] reqSet = '0;
  logic [2:0] curMask = '0;
  logic [1:0] traceIn = '0;
  logic       ack = 1'b0;
  logic       take, resume;
  logic [2:0] level, newMask;
  logic [7:0] vecOffset;
  logic [1:0] newTrace;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string curReq = "R1";

  // reference model state
  int pendM = 0, lvlM = 0, ofsM = 0, nmM = 0, ntM = 0;
  bit takeM = 0, resM = 0;

  always #10 clk = ~clk;

  irq_autovec_arb uut (
    .clk(clk), .rstN(rstN), .reqSet(reqSet), .curMask(curMask),
    .traceIn(traceIn), .ack(ack), .take(take), .level(level),
    .vecOffset(vecOffset), .newMask(newMask), .newTrace(newTrace),
    .resume(resume)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      pendM = 0; takeM = 0; lvlM = 0; ofsM = 0; nmM = 0; ntM = 0; resM = 0;
    end else begin
      bit acc, tk;
      int hi, np;
      acc = ack && takeM;
      hi = 0;
      for (int i = 1; i <= 7; i++) if (pendM[i-1]) hi = i;
      tk = (hi == 7) || (hi != 0 && hi > int'(curMask));
      np = pendM;
      if (acc) np = np & ~(1 << (lvlM - 1));
      np = np | int'(reqSet);
      nmM  = acc ? lvlM : int'(curMask);
      ntM  = acc ? 0 : int'(traceIn);
      resM = acc;
      takeM = tk;
      lvlM = tk ? hi : 0;
      ofsM = tk ? (hi + 24) * 4 : 0;
      pendM = np;
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      cmp("take", int'(take), int'(takeM));
      cmp("level", int'(level), lvlM);
      cmp("vecOffset", int'(vecOffset), ofsM);
      cmp("newMask", int'(newMask), nmM);
      cmp("newTrace", int'(newTrace), ntM);
      cmp("resume", int'(resume), int'(resM));
    end
  end

  task automatic cyc(input logic [6:0] r, input logic [2:0] m,
                     input logic [1:0] t, input logic a);
    @(negedge clk);
    #2;
    reqSet = r; curMask = m; traceIn = t; ack = a;
  endtask

  task automatic idle(input int n, input logic [2:0] m);
    for (int k = 0; k < n; k++) cyc(7'd0, m, 2'b00, 1'b0);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    idle(3, 3'd0);
    @(negedge clk); #2; rstN = 1'b1;
    idle(2, 3'd0);

    // R2: nothing pending
    curReq = "R2";
    idle(4, 3'd0);

    // R10: single pulse stays pending without ack
    curReq = "R10";
    cyc(7'b0000100, 3'd0, 2'b00, 1'b0);
    idle(6, 3'd0);

    // R4: equal mask blocks, lower mask allows
    curReq = "R4";
    idle(3, 3'd3);
    idle(3, 3'd2);
    cyc(7'b0000000, 3'd2, 2'b00, 1'b1);   // accept level 3
    idle(3, 3'd0);

    // R7: two pending, accept highest, lower follows
    curReq = "R7";
    cyc(7'b0010010, 3'd0, 2'b00, 1'b0);   // levels 2 and 5
    idle(2, 3'd0);
    cyc(7'b0000000, 3'd0, 2'b00, 1'b1);   // accept 5
    idle(3, 3'd0);
    cyc(7'b0000000, 3'd0, 2'b00, 1'b1);   // accept 2
    idle(3, 3'd0);

    // R3: level 7 ignores mask 7
    curReq = "R3";
    cyc(7'b1000001, 3'd7, 2'b00, 1'b0);
    idle(3, 3'd7);
    cyc(7'b0000000, 3'd7, 2'b00, 1'b1);
    idle(3, 3'd7);

    // R9: ack with nothing taken (level 1 pending under mask 7)
    curReq = "R9";
    cyc(7'b0000000, 3'd7, 2'b00, 1'b1);
    cyc(7'b0000000, 3'd7, 2'b00, 1'b1);
    idle(2, 3'd0);
    cyc(7'b0000000, 3'd0, 2'b00, 1'b1);   // accept level 1
    idle(2, 3'd0);

    // R8: same-level request during acceptance
    curReq = "R8";
    cyc(7'b0001000, 3'd0, 2'b00, 1'b0);   // level 4
    idle(2, 3'd0);
    cyc(7'b0001000, 3'd0, 2'b00, 1'b1);   // accept 4 and re-request 4
    idle(3, 3'd0);
    cyc(7'b0000000, 3'd0, 2'b00, 1'b1);
    idle(3, 3'd0);

    // R6: trace pass-through and clearing, mask follow
    curReq = "R6";
    cyc(7'b0100000, 3'd1, 2'b11, 1'b0);   // level 6
    cyc(7'b0000000, 3'd1, 2'b11, 1'b0);
    cyc(7'b0000000, 3'd1, 2'b10, 1'b1);   // accept 6
    cyc(7'b0000000, 3'd5, 2'b01, 1'b0);
    cyc(7'b0000000, 3'd5, 2'b11, 1'b0);
    idle(2, 3'd0);

    // R5: offsets for every level in turn
    curReq = "R5";
    for (int l = 1; l <= 7; l++) begin
      cyc(7'(1 << (l - 1)), 3'd0, 2'b00, 1'b0);
      idle(2, 3'd0);
      cyc(7'd0, 3'd0, 2'b00, 1'b1);
      idle(2, 3'd0);
    end

    // R11: random traffic
    curReq = "R11";
    for (int k = 0; k < 2000; k++) begin
      logic [6:0] r;
      r = ($urandom_range(0, 3) == 0) ? 7'($urandom_range(0, 127)) : 7'd0;
      cyc(r, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
          1'($urandom_range(0, 1)));
    end
    idle(4, 3'd0);
    finish_run();
  end
endmodule